// File: doc/BRIEF.md
# JTAG Register Access Scan Chain

This block is the data-register end of a debug access path. A TAP controller outside the block decodes the instruction and selects the scan chain. It then hands the block a select line and the capture, shift and update strobes, all timed on TCK. Each complete scan carries one 40-bit command. The block turns that command into a single read or write strobe on a simple register bus that runs on the system clock. A peripheral such as an on-chip trace buffer sits on that bus.

Reads are split across two scans. A read scan names an address, and the bus read is launched when that scan reaches update. The data that comes back is held by the block. It is loaded into the scan register at the next capture and is shifted out during the next scan. Debug software can stream a memory-like data register by sending the same read address over and over. Each scan returns the previous word and starts the read of the next one. The last scan of such a run names a harmless address, so that no extra word is consumed.

The request crosses from TCK to the system clock as a toggle through a two-flop synchroniser. An edge detector then forms a strobe that is exactly one system-clock cycle wide. The command fields sit in a holding register that stays stable while the toggle crosses. A read scan that was aborted before all 40 bits were shifted produces no strobe.

Top module: `jtag_reg_bridge`

## Requirements
- R1: The scan register is 40 bits wide and is shifted least significant bit first, taking TDI into bit 39 and presenting bit 0 on TDO. Bits 31:0 hold data, bits 38:32 hold the register address, and bit 39 holds the direction flag (1 = write, 0 = read).
- R2: A write scan gives exactly one `bus_we` pulse, one system-clock cycle wide, with `bus_addr` and `bus_wdata` taken from the scan. No `bus_re` pulse is produced.
- R3: A complete read scan gives exactly one `bus_re` pulse, one system-clock cycle wide, with `bus_addr` taken from the scan. No `bus_we` pulse is produced.
- R4: At capture, bits 31:0 of the scan register are loaded with the most recent read result and bits 39:32 are loaded with zero. The read result of one scan therefore appears in the data field of the following scan.
- R5: When scans read the same data address back to back, they return successive words, each read once. A closing scan to address 0 returns the last word without a further read of the data address.
- R6: A read scan whose update arrives after fewer than 40 shift cycles produces no bus strobe.
- R7: While `sel` is low, the capture, shift and update strobes have no effect: no bus strobe is produced and the held read result is unchanged.
- R8: After reset, both strobes are low and the held read result is zero, so the first scan shifts out all zeros.
- R9: A write does not change the held read result. The scan that follows a write shifts out the result of the last read.
- R10: `bus_we` and `bus_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| sel | input | 1 | This data register is selected by the TAP |
| capture_dr | input | 1 | TAP is in the capture state |
| shift_dr | input | 1 | TAP is in the shift state |
| update_dr | input | 1 | TAP is in the update state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |
| sys_clk | input | 1 | System clock of the register bus |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_re` |

## Verification
The bench streams three words from a modelled buffer. It then checks that the closing scan to address 0 leaves the buffer's read pointer at exactly three. A design that read on every capture, or that read again on the closing scan, would skip a word and move the pointer past three. It sends an aborted read of 20 bits. A design that did not count shifts would issue a strobe and advance the pointer. It also checks that a write followed by a scan still returns the last read value; a design that captured bus write data into the read holding register would fail here. Deselected scans, a reset in the middle of the run, and the zero upper byte at capture complete the set.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int SCAN_W = DATA_W + ADDR_W + 1;
    localparam int CNT_W  = $clog2(SCAN_W + 1);

    // Packed MSB first: wr is bit 39, addr bits 38:32, data bits 31:0.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_cmd_t;

    function automatic logic [SCAN_W-1:0] capture_word(input logic [DATA_W-1:0] d);
        return {{(SCAN_W - DATA_W){1'b0}}, d};
    endfunction

    function automatic logic scan_full(input logic [CNT_W-1:0] cnt);
        return cnt == CNT_W'(SCAN_W);
    endfunction

endpackage

// File: rtl/jrb_shift.sv
module jrb_shift
    import jrb_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [DATA_W-1:0] rd_hold,
    output scan_cmd_t         cmd,
    output logic              req_tog
);

    logic [SCAN_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    scan_cmd_t         incoming;

    assign incoming = scan_cmd_t'(sr);
    assign tdo      = sr[0];

    always_ff @(posedge tck) begin
        if (rst) begin
            sr      <= '0;
            cnt     <= '0;
            cmd     <= '0;
            req_tog <= 1'b0;
        end else if (sel) begin
            if (capture_dr) begin
                sr  <= capture_word(rd_hold);
                cnt <= '0;
            end else if (shift_dr) begin
                sr <= {tdi, sr[SCAN_W-1:1]};
                if (!scan_full(cnt))
                    cnt <= cnt + 1'b1;
            end else if (update_dr) begin
                if (incoming.wr || scan_full(cnt)) begin
                    cmd     <= incoming;
                    req_tog <= ~req_tog;
                end
            end
        end
    end

    p_cnt_bound_r6: assert property (@(posedge tck) disable iff (rst)
        cnt <= CNT_W'(SCAN_W));

    p_capture_upper_zero_r4: assert property (@(posedge tck) disable iff (rst)
        (sel && capture_dr) |=> (sr[SCAN_W-1:DATA_W] == '0));

    p_abort_read_quiet_r6: assert property (@(posedge tck) disable iff (rst)
        (sel && update_dr && !capture_dr && !shift_dr && !sr[SCAN_W-1] && !scan_full(cnt))
        |=> $stable(req_tog));

    p_deselect_quiet_r7: assert property (@(posedge tck) disable iff (rst)
        !sel |=> $stable(req_tog));

endmodule

// File: rtl/jrb_sync.sv
module jrb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], tog_in};
    end

    assign pulse = chain[STAGES] ^ chain[STAGES-1];

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/jrb_bus.sv
module jrb_bus
    import jrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  scan_cmd_t         cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rd_hold
);

    logic re_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
            re_q      <= 1'b0;
            rd_hold   <= '0;
        end else begin
            bus_we <= go && cmd.wr;
            bus_re <= go && !cmd.wr;
            re_q   <= bus_re;
            if (go) begin
                bus_addr  <= cmd.addr;
                bus_wdata <= cmd.data;
            end
            if (re_q)
                rd_hold <= bus_rdata;
        end
    end

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

    p_we_width_r2: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);

    p_re_width_r3: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> !bus_re);

    p_hold_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !re_q) |=> $stable(rd_hold));

endmodule

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge
    import jrb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              tck,
    input  logic              tck_rst,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              sys_clk,
    input  logic              sys_rst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);

    scan_cmd_t         cmd;
    logic              req_tog;
    logic              go;
    logic [DATA_W-1:0] rd_hold;

    jrb_shift u_shift (
        .tck        (tck),
        .rst        (tck_rst),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .rd_hold    (rd_hold),
        .cmd        (cmd),
        .req_tog    (req_tog)
    );

    jrb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (sys_clk),
        .rst    (sys_rst),
        .tog_in (req_tog),
        .pulse  (go)
    );

    jrb_bus u_bus (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .go        (go),
        .cmd       (cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .rd_hold   (rd_hold)
    );

endmodule

// File: tb/tb_jtag_reg_bridge.sv
module tb_jtag_reg_bridge;

    localparam logic [31:0] ID_WORD  = 32'h0B11_D00D;
    localparam logic [31:0] RAM_BASE = 32'hA000_0000;
    localparam int          NVEC     = 10;

    // {wr, addr[6:0], data[31:0], expected shift-out data[31:0]}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 7'd5, 32'hDEAD_BEEF, 32'h0000_0000},
        {1'b0, 7'd5, 32'h0,         32'h0000_0000},
        {1'b0, 7'd0, 32'h0,         32'hDEAD_BEEF},
        {1'b0, 7'd4, 32'h0,         ID_WORD},
        {1'b0, 7'd4, 32'h0,         RAM_BASE + 32'd0},
        {1'b0, 7'd4, 32'h0,         RAM_BASE + 32'd1},
        {1'b0, 7'd0, 32'h0,         RAM_BASE + 32'd2},
        {1'b1, 7'd9, 32'h1234_5678, ID_WORD},
        {1'b0, 7'd9, 32'h0,         ID_WORD},
        {1'b0, 7'd0, 32'h0,         32'h1234_5678}
    };

    logic tck = 1'b0, sys_clk = 1'b0;
    logic tck_rst, sys_rst, sel, capture_dr, shift_dr, update_dr, tdi, tdo;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_we, bus_re;

    always #50 tck = ~tck;
    always #10 sys_clk = ~sys_clk;

    jtag_reg_bridge dut (
        .tck(tck), .tck_rst(tck_rst), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .sys_clk(sys_clk), .sys_rst(sys_rst), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata)
    );

    // Peripheral model: ID at 0, streaming buffer at 4, plain registers elsewhere.
    logic [31:0] regs [16];
    int ram_ptr = 0;
    int n_we = 0, n_re = 0, bad_width = 0, cycles = 0;
    logic [6:0]  last_waddr, last_raddr;
    logic [31:0] last_wdata;
    logic we_prev = 1'b0, re_prev = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;

    always @(posedge sys_clk) begin
        we_prev <= bus_we;
        re_prev <= bus_re;
        if ((bus_we && we_prev) || (bus_re && re_prev)) bad_width <= bad_width + 1;
        if (bus_we) begin
            n_we       <= n_we + 1;
            last_waddr <= bus_addr;
            last_wdata <= bus_wdata;
            regs[bus_addr[3:0]] <= bus_wdata;
        end
        if (bus_re) begin
            n_re       <= n_re + 1;
            last_raddr <= bus_addr;
            if (bus_addr == 7'd0)      bus_rdata <= ID_WORD;
            else if (bus_addr == 7'd4) begin
                bus_rdata <= RAM_BASE + 32'(ram_ptr);
                ram_ptr   <= ram_ptr + 1;
            end else                   bus_rdata <= regs[bus_addr[3:0]];
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge sys_clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: got hang, expected completion");
            report();
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic scan(input logic s, input logic [39:0] din, input int nbits,
                        output logic [39:0] dout);
        dout = '0;
        @(negedge tck);
        sel = s; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            tdi     = din[i];
            dout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0; sel = 1'b0;
        repeat (4) @(negedge tck);
    endtask

    task automatic do_reset();
        tck_rst = 1'b1; sys_rst = 1'b1;
        repeat (3) @(negedge tck);
        tck_rst = 1'b0; sys_rst = 1'b0;
        repeat (2) @(negedge tck);
    endtask

    initial begin
        logic [39:0] dout;
        int we0, re0, p0;
        sel = 0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
        bus_rdata = '0;
        for (int i = 0; i < 16; i++) regs[i] = 32'h0;
        do_reset();

        // R8: strobes idle after reset
        check("R8 strobes", {62'b0, bus_we, bus_re}, 64'd0);

        // Vector table walk (R1..R5, R9)
        for (int v = 0; v < NVEC; v++) begin
            we0 = n_we; re0 = n_re;
            scan(1'b1, VEC[v][71:32], 40, dout);
            check("R4 shift-out data", 64'(dout[31:0]), 64'(VEC[v][31:0]));
            check("R4 upper byte zero", 64'(dout[39:32]), 64'd0);
            if (VEC[v][71]) begin
                check("R2 write pulses", {32'(n_we - we0), 32'(n_re - re0)}, {32'd1, 32'd0});
                check("R1 R2 write fields", {25'b0, last_waddr, last_wdata},
                      {25'b0, VEC[v][70:64], VEC[v][63:32]});
            end else begin
                check("R3 read pulses", {32'(n_we - we0), 32'(n_re - re0)}, {32'd0, 32'd1});
                check("R1 R3 read addr", 64'(last_raddr), 64'(VEC[v][70:64]));
            end
        end
        // R5: three buffer words consumed, no extra read on the closing scan
        check("R5 buffer pointer", 64'(ram_ptr), 64'd3);

        // R6: aborted read of the buffer address
        we0 = n_we; re0 = n_re; p0 = ram_ptr;
        scan(1'b1, {1'b0, 7'd4, 32'h0}, 20, dout);
        check("R6 aborted read no strobe", {32'(n_re - re0), 32'(ram_ptr - p0)}, 64'd0);
        check("R6 aborted scan out", 64'(dout[19:0]), 64'(ID_WORD[19:0]));

        // R7: deselected write and read scans
        we0 = n_we; re0 = n_re;
        scan(1'b0, {1'b1, 7'd5, 32'h5555_AAAA}, 40, dout);
        scan(1'b0, {1'b0, 7'd5, 32'h0}, 40, dout);
        check("R7 deselected no strobe", {32'(n_we - we0), 32'(n_re - re0)}, 64'd0);
        scan(1'b1, {1'b0, 7'd5, 32'h0}, 40, dout);
        check("R7 hold unchanged", 64'(dout[31:0]), 64'(ID_WORD));
        scan(1'b1, {1'b0, 7'd0, 32'h0}, 40, dout);
        check("R7 register not written", 64'(dout[31:0]), 64'hDEAD_BEEF);

        // R2 R3 R10: strobe widths never exceeded one cycle
        check("R10 R2 R3 pulse width", 64'(bad_width), 64'd0);

        // R8: reset mid-run clears the held read result
        do_reset();
        scan(1'b1, {1'b0, 7'd0, 32'h0}, 40, dout);
        check("R8 first scan after reset", 64'(dout), 64'd0);

        done = 1;
        report();
    end

endmodule